// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs an external 8-bit successive-approximation converter that has an 8-input analog multiplexer in front of it. The block lives inside the FPGA and is clocked by the system clock. It divides that clock down to make the converter clock. It then drives the channel-select lines, the address-latch pulse, the start pulse and the output-enable strobe. The timing of each of these is counted in whole converter-clock periods.

For every conversion the block goes through a fixed handshake. First it presents the channel address and lets it settle. Then it latches the address into the multiplexer and waits a programmable number of periods. Next it pulses start, whose rising edge clears the converter and whose falling edge begins the conversion. The block then waits for the end-of-conversion flag to rise, which it sees through a two-stage synchronizer. One clock after that it raises output-enable and samples the byte while output-enable is still high.

A channel-enable mask chooses the inputs to scan. The sequencer visits the enabled inputs in ascending order and wraps around. Each result leaves the block with its channel number and a one-clock valid pulse. If the converter never reports completion, a timeout abandons that channel, flags an error and moves on to the next channel.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is held, adcAle, adcStart, adcOe, resultValid and timeoutErr are low and adcAddr equals NUM_CH-1 (all ones).
- R2: adcClk runs freely with a period of 2*CLK_HALF system clocks. It is high for exactly CLK_HALF clocks and low for exactly CLK_HALF clocks.
- R3: adcAddr takes a new value at least one converter period (2*CLK_HALF clocks) before adcAle rises. It keeps that value through the start pulse, so the value at the rise of adcStart equals the value latched by adcAle.
- R4: adcAle is high for exactly one converter period. adcStart rises exactly SETTLE_PERIODS converter periods after adcAle falls and is high for exactly one period. The two are never high together.
- R5: A rise of adcEoc passes two synchronizing flip-flops and an edge detector. adcOe then rises one system clock after the detection, which is exactly four system clocks after the rise of adcEoc. adcOe never rises without a detected rise.
- R6: adcOe stays high for exactly two system clocks. adcData is sampled at the last clock edge at which adcOe is still high.
- R7: Each captured byte appears on resultData, with its channel on resultCh, together with resultValid high for exactly one clock.
- R8: Channel n is enabled by chEnMask bit n, and adcAddr bit 2 is the most significant select bit. After channel c, the next channel converted is the first enabled channel above c, wrapping from 7 to 0. The mask is read at the moment the next channel is chosen.
- R9: While chEnMask is zero, no adcAle pulse is issued. A conversion already in progress still completes.
- R10: If adcEoc gives no rise within TIMEOUT_PERIODS converter periods after adcStart falls, timeoutErr pulses for one clock. The pulse comes exactly TIMEOUT_PERIODS*2*CLK_HALF clocks after that fall, with resultCh holding the channel. No valid pulse and no adcOe pulse are issued for that conversion, and scanning continues with the next channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chEnMask | input | NUM_CH | Channel-enable mask, bit n enables channel n |
| adcClk | output | 1 | Divided converter clock |
| adcAddr | output | $clog2(NUM_CH) | Multiplexer channel-select lines, bit 2 most significant |
| adcAle | output | 1 | Address-latch pulse to the multiplexer |
| adcStart | output | 1 | Conversion start pulse |
| adcOe | output | 1 | Output-enable strobe for the converter's tri-state latch |
| adcEoc | input | 1 | End-of-conversion flag, asynchronous |
| adcData | input | DATA_W | Converter result byte |
| resultData | output | DATA_W | Last captured result |
| resultCh | output | $clog2(NUM_CH) | Channel of the last result or timeout |
| resultValid | output | 1 | One-clock pulse per captured result |
| timeoutErr | output | 1 | One-clock pulse when a conversion times out |

## Verification
The hardest situation to reach from the ports is the timeout path: it needs a converter that takes a start pulse and then never reports completion. The behavioural converter in the bench has a one-shot hang flag. Once armed, it swallows the next start and leaves its flag low, and the bench measures the distance from the fall of start to the error pulse. The idle state reached through an empty mask is also hard to hit. The mask has to drop to zero on the very clock the result pulse appears, before the sequencer picks its next channel. The bench therefore changes the mask from inside the same wait loop that detects the pulse, and then restarts scanning with a different mask to confirm that the round-robin order resumes after the last converted channel.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LATCH,
    ST_SETTLE,
    ST_START,
    ST_WAIT,
    ST_OEDLY,
    ST_OEON,
    ST_CAPT,
    ST_NEXT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCh;       // choose next enabled channel
    logic capture;      // sample converter byte
    logic flagTimeout;  // report abandoned conversion
  } seqStrobe_t;

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv #(
  parameter int CLK_HALF = 25
) (
  input  logic clk,
  input  logic rstN,
  output logic convClk,
  output logic periodTick
);
  localparam int PERIOD = 2 * CLK_HALF;
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] divCnt;

  assign periodTick = (divCnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      convClk <= 1'b0;
    end else if (periodTick) begin
      divCnt  <= '0;
      convClk <= 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
      if (divCnt == CW'(CLK_HALF - 1)) convClk <= 1'b0;
    end
  end

  // R2
  tick_rises_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodTick |=> $rose(convClk));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int SETTLE_PERIODS  = 2,
  parameter int TIMEOUT_PERIODS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodTick,
  input  logic       eocRise,
  input  logic       maskAny,
  output seqStrobe_t strb,
  output logic       adcAle,
  output logic       adcStart,
  output logic       adcOe
);
  localparam int CNT_MAX = (TIMEOUT_PERIODS > SETTLE_PERIODS) ?
                           ((TIMEOUT_PERIODS > 2) ? TIMEOUT_PERIODS : 2) :
                           ((SETTLE_PERIODS > 2) ? SETTLE_PERIODS : 2);
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  seqState_e  state, nextState;
  logic [CNT_W-1:0] phaseCnt, nextCnt;

  always_comb begin
    nextState = state;
    nextCnt   = phaseCnt;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (maskAny) begin
          strb.loadCh = 1'b1;
          nextState   = ST_SETUP;
          nextCnt     = '0;
        end
      end
      ST_SETUP: begin
        if (periodTick) begin
          if (phaseCnt == CNT_W'(1)) begin
            nextState = ST_LATCH;
            nextCnt   = '0;
          end else begin
            nextCnt = phaseCnt + 1'b1;
          end
        end
      end
      ST_LATCH: begin
        if (periodTick) begin
          nextState = ST_SETTLE;
          nextCnt   = '0;
        end
      end
      ST_SETTLE: begin
        if (periodTick) begin
          if (phaseCnt == CNT_W'(SETTLE_PERIODS - 1)) begin
            nextState = ST_START;
            nextCnt   = '0;
          end else begin
            nextCnt = phaseCnt + 1'b1;
          end
        end
      end
      ST_START: begin
        if (periodTick) begin
          nextState = ST_WAIT;
          nextCnt   = '0;
        end
      end
      ST_WAIT: begin
        if (eocRise) begin
          nextState = ST_OEDLY;
        end else if (periodTick) begin
          if (phaseCnt == CNT_W'(TIMEOUT_PERIODS - 1)) begin
            strb.flagTimeout = 1'b1;
            nextState        = ST_NEXT;
          end else begin
            nextCnt = phaseCnt + 1'b1;
          end
        end
      end
      ST_OEDLY: nextState = ST_OEON;
      ST_OEON:  nextState = ST_CAPT;
      ST_CAPT: begin
        strb.capture = 1'b1;
        nextState    = ST_NEXT;
      end
      ST_NEXT: begin
        if (maskAny) begin
          strb.loadCh = 1'b1;
          nextState   = ST_SETUP;
          nextCnt     = '0;
        end else begin
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= nextState;
      phaseCnt <= nextCnt;
    end
  end

  assign adcAle   = (state == ST_LATCH);
  assign adcStart = (state == ST_START);
  assign adcOe    = (state == ST_OEON) || (state == ST_CAPT);

  // R4
  latch_start_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(adcAle && adcStart));

  // R5
  oe_after_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcOe) |-> $past(eocRise, 2));

endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic [NUM_CH-1:0]         chEnMask,
  input  logic                      adcEoc,
  input  logic [DATA_W-1:0]         adcData,
  output logic [$clog2(NUM_CH)-1:0] adcAddr,
  output logic                      eocRise,
  output logic                      maskAny,
  output logic [DATA_W-1:0]         resultData,
  output logic [$clog2(NUM_CH)-1:0] resultCh,
  output logic                      resultValid,
  output logic                      timeoutErr
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] curCh, pickCh;
  logic            found;
  logic            eocMeta, eocSync, eocPrev;

  assign maskAny = |chEnMask;
  assign eocRise = eocSync & ~eocPrev;
  assign adcAddr = curCh;

  // first enabled channel strictly above curCh, wrapping
  always_comb begin
    pickCh = curCh;
    found  = 1'b0;
    for (int step = 1; step <= NUM_CH; step++) begin
      automatic int idx = (int'(curCh) + step) % NUM_CH;
      if (!found && chEnMask[idx]) begin
        pickCh = CH_W'(idx);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eocMeta <= 1'b0;
      eocSync <= 1'b0;
      eocPrev <= 1'b0;
    end else begin
      eocMeta <= adcEoc;
      eocSync <= eocMeta;
      eocPrev <= eocSync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCh       <= CH_W'(NUM_CH - 1);
      resultData  <= '0;
      resultCh    <= '0;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      timeoutErr  <= strb.flagTimeout;
      if (strb.loadCh) curCh <= pickCh;
      if (strb.capture) begin
        resultData <= adcData;
        resultCh   <= curCh;
      end
      if (strb.flagTimeout) resultCh <= curCh;
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R10
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && timeoutErr));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adcseq_pkg::*;
#(
  parameter int NUM_CH          = 8,
  parameter int DATA_W          = 8,
  parameter int CLK_HALF        = 25,
  parameter int SETTLE_PERIODS  = 2,
  parameter int TIMEOUT_PERIODS = 100
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         chEnMask,
  output logic                      adcClk,
  output logic [$clog2(NUM_CH)-1:0] adcAddr,
  output logic                      adcAle,
  output logic                      adcStart,
  output logic                      adcOe,
  input  logic                      adcEoc,
  input  logic [DATA_W-1:0]         adcData,
  output logic [DATA_W-1:0]         resultData,
  output logic [$clog2(NUM_CH)-1:0] resultCh,
  output logic                      resultValid,
  output logic                      timeoutErr
);
  seqStrobe_t strb;
  logic       periodTick;
  logic       eocRise;
  logic       maskAny;

  adcseq_clkdiv #(.CLK_HALF(CLK_HALF)) u_clkdiv (
    .clk       (clk),
    .rstN      (rstN),
    .convClk   (adcClk),
    .periodTick(periodTick)
  );

  adcseq_ctrl #(
    .SETTLE_PERIODS (SETTLE_PERIODS),
    .TIMEOUT_PERIODS(TIMEOUT_PERIODS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .periodTick(periodTick),
    .eocRise   (eocRise),
    .maskAny   (maskAny),
    .strb      (strb),
    .adcAle    (adcAle),
    .adcStart  (adcStart),
    .adcOe     (adcOe)
  );

  adcseq_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .chEnMask   (chEnMask),
    .adcEoc     (adcEoc),
    .adcData    (adcData),
    .adcAddr    (adcAddr),
    .eocRise    (eocRise),
    .maskAny    (maskAny),
    .resultData (resultData),
    .resultCh   (resultCh),
    .resultValid(resultValid),
    .timeoutErr (timeoutErr)
  );

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcAle || adcStart) |=> $stable(adcAddr));

endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int P          = 2 * HALF;
  localparam int SETTLE     = 2;
  localparam int TOUT       = 100;
  localparam int CONV_CLKS  = 66;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] chEnMask = 8'h00;
  logic       adcClk, adcAle, adcStart, adcOe, resultValid, timeoutErr;
  logic [2:0] adcAddr, resultCh;
  logic       adcEoc = 1'b1;
  logic [7:0] dataLatch = 8'h00;
  logic [7:0] adcData, resultData;

  assign adcData = adcOe ? dataLatch : 8'hEE;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq #(
    .NUM_CH(8), .DATA_W(8), .CLK_HALF(HALF),
    .SETTLE_PERIODS(SETTLE), .TIMEOUT_PERIODS(TOUT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .chEnMask(chEnMask),
    .adcClk(adcClk), .adcAddr(adcAddr), .adcAle(adcAle),
    .adcStart(adcStart), .adcOe(adcOe), .adcEoc(adcEoc),
    .adcData(adcData), .resultData(resultData), .resultCh(resultCh),
    .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  typedef struct { bit isErr; logic [2:0] ch; logic [7:0] data; } item_t;
  item_t expQ[$];

  int vectors = 0;
  int miscompares = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] nextEnabled(input logic [2:0] last, input logic [7:0] m);
    logic [2:0] r = last;
    bit hit = 0;
    for (int s = 1; s <= 8; s++) begin
      automatic int k = (int'(last) + s) % 8;
      if (!hit && m[k]) begin r = 3'(k); hit = 1; end
    end
    return r;
  endfunction

  // converter model and timing monitor
  int cyc = 0, addrChg = 0, aleRise = 0, aleFall = 0, startRise = 0, startFall = 0;
  int eocSetCyc = -100, oeRise = 0, clkEdge = 0, clkChecks = 0, convCnt = 0, convIdx = 0;
  int aleRises = 0, hungStart = 0;
  bit prevAle = 0, prevStart = 0, prevOe = 0, prevClk = 0, prevValid = 0;
  bit converting = 0, hangNext = 0, expectTimeout = 0;
  logic [2:0] prevAddr = 3'd7, latchedCh = 3'd0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (adcAddr !== prevAddr) addrChg = cyc;
      if (rstN && adcClk !== prevClk) begin
        if (clkEdge > 0 && clkChecks < 8) begin
          clkChecks++;
          check(cyc - clkEdge == HALF, "R2", "converter clock half period", cyc - clkEdge, HALF);
        end
        clkEdge = cyc;
        if (adcClk && converting) begin
          convCnt++;
          if (convCnt == CONV_CLKS) begin
            converting = 0;
            dataLatch  = 8'(int'(latchedCh) * 29 + convIdx * 7 + 3);
            expQ.push_back('{0, latchedCh, dataLatch});
            convIdx++;
            adcEoc    = 1'b1;
            eocSetCyc = cyc;
          end
        end
      end
      if (adcAle && !prevAle) begin
        aleRise = cyc; aleRises++; latchedCh = adcAddr;
        check(cyc - addrChg >= P, "R3", "address setup before latch", cyc - addrChg, P);
      end
      if (!adcAle && prevAle) begin
        aleFall = cyc;
        check(cyc - aleRise == P, "R4", "latch pulse width", cyc - aleRise, P);
      end
      if (adcStart && !prevStart) begin
        startRise = cyc; adcEoc = 1'b0;
        check(cyc - aleFall == SETTLE * P, "R4", "latch to start gap", cyc - aleFall, SETTLE * P);
        check(adcAddr == latchedCh, "R3", "address held at start", adcAddr, latchedCh);
      end
      if (!adcStart && prevStart) begin
        startFall = cyc;
        check(cyc - startRise == P, "R4", "start pulse width", cyc - startRise, P);
        if (hangNext) begin
          hangNext = 0; expectTimeout = 1; hungStart = cyc;
          expQ.push_back('{1, latchedCh, 8'h00});
        end else begin
          converting = 1; convCnt = 0;
        end
      end
      if (adcOe && !prevOe) begin
        oeRise = cyc;
        check(cyc - eocSetCyc == 4, "R5", "eoc rise to output enable", cyc - eocSetCyc, 4);
      end
      if (!adcOe && prevOe)
        check(cyc - oeRise == 2, "R6", "output enable width", cyc - oeRise, 2);
      if (resultValid)
        check(!prevValid, "R7", "valid pulse longer than one clock", 1, 0);
      if (timeoutErr && expectTimeout) begin
        expectTimeout = 0;
        check(cyc - hungStart == TOUT * P, "R10", "timeout delay", cyc - hungStart, TOUT * P);
      end
      prevAle = adcAle; prevStart = adcStart; prevOe = adcOe; prevClk = adcClk;
      prevAddr = adcAddr; prevValid = resultValid;
    end
  end

  // scoreboard monitor
  logic [7:0] maskForCheck = 8'h00;
  logic [2:0] lastCh = 3'd7;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (resultValid || timeoutErr)) begin
        automatic logic [2:0] expCh = nextEnabled(lastCh, maskForCheck);
        check(resultCh == expCh, "R8", "round-robin channel", resultCh, expCh);
        lastCh = resultCh;
        if (expQ.size() == 0) begin
          check(0, "R7", "result with no expected item", resultCh, -1);
        end else begin
          automatic item_t it = expQ.pop_front();
          check(timeoutErr == it.isErr, "R10", "timeout flag", timeoutErr, it.isErr);
          check(resultCh == it.ch, "R7", "result channel", resultCh, it.ch);
          if (resultValid && !it.isErr)
            check(resultData == it.data, "R7", "result data", resultData, it.data);
        end
      end
    end
  end

  task automatic waitResults(input int n);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      if (resultValid || timeoutErr) got++;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R7", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!adcAle && !adcStart && !adcOe, "R1", "controls low in reset", {adcAle, adcStart, adcOe}, 0);
    check(!resultValid && !timeoutErr, "R1", "flags low in reset", {resultValid, timeoutErr}, 0);
    check(adcAddr == 3'd7, "R1", "address in reset", adcAddr, 7);
    rstN = 1'b1;
    repeat (100) @(negedge clk);
    check(aleRises == 0, "R9", "latch issued with empty mask", aleRises, 0);

    chEnMask = 8'hFF; maskForCheck = 8'hFF;
    waitResults(10);
    chEnMask = 8'h00;
    @(negedge clk);
    maskForCheck = 8'h00;
    n = aleRises;
    repeat (300) @(negedge clk);
    check(aleRises == n, "R9", "latch after mask cleared", aleRises, n);

    chEnMask = 8'h85; maskForCheck = 8'h85;
    waitResults(6);
    hangNext = 1;
    waitResults(5);
    chEnMask = 8'h00;
    @(negedge clk);
    maskForCheck = 8'h00;
    repeat (200) @(negedge clk);

    chEnMask = 8'h10; maskForCheck = 8'h10;
    waitResults(3);
    repeat (50) @(negedge clk);
    check(expQ.size() == 0, "R7", "unmatched expected items", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule